// File: doc/BRIEF.md
# Page ECC Syndrome Checker and Single-Bit Corrector

This block checks a 2048-byte flash page that was read back as four 512-byte sectors. For each sector it compares the 24-bit Hamming parity code held in the spare area with the code computed over the data on readback. From those two codes it decides whether the sector is clean, holds one flipped data bit that can be repaired, or is beyond repair. A repair is made in place: the block reads the faulty byte from the page buffer, flips the one bit, and writes the byte back.

Firmware or a read engine puts all eight codes on two flat input vectors, then pulses `start`. The block steps through the sectors from lowest to highest. It stops at the first sector it cannot repair. It finishes with a one-cycle `done` pulse, a two-bit page status, and a per-sector mask of the sectors it repaired. A sector that was erased is blank in both its data and its code area, and it is accepted as clean.

Top module: `page_ecc_corrector`

## Requirements
- R1: After reset `done`, `buf_rd_en`, `buf_wr_en` and `fix_valid` are low and `corr_flags` is zero.
- R2: A sector whose stored and computed codes are equal is clean and causes no page-buffer access.
- R3: Each 24-bit code is packed as {odd[11:0], even[11:0]}, where even[k] and odd[k] are the even and odd line/column parities of weight 2^k. The syndrome interleaves the XOR of the two codes so that bit 2k is the even difference and bit 2k+1 is the odd difference of weight 2^k.
- R4: When exactly 12 syndrome bits are set, the sector has a correctable error. The bit index is the odd differences of weights 4, 2, 1 (MSB to LSB). The byte offset is the odd differences of weights 2048 down to 8, taken as 9 bits, MSB to LSB. Both are reported on `fix_sector`, `fix_byte` and `fix_bit` while `fix_valid` is high.
- R5: A repair is a read of page address {sector, byte offset}. The read data returns one cycle after `buf_rd_en`. The block then writes that data, with only the indexed bit inverted, to the same address. The write comes two cycles after the read request, and after it the sector's bit in `corr_flags` is set.
- R6: A syndrome population count other than 0 or 12 marks the sector uncorrectable. This covers counts of 1, 11, 13 and 24 alike.
- R7: A sector whose stored code is all ones and whose computed code equals the blank-sector code (all zeros by default) is treated as clean, with no buffer access.
- R8: Sectors are checked in order 0 to 3. At the first uncorrectable sector, processing stops with status FAIL, and `err_sector` holds that sector's number. Later sectors are neither read nor repaired.
- R9: `done` is a one-cycle pulse. `status` is 0 for a clean page, 1 when at least one sector was repaired and none failed, and 2 when a sector failed. `status` never reads 3 at `done`.
- R10: A `start` pulse that arrives while a page is being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin checking a page (accepted when idle) |
| stored_ecc | input | 96 | Codes read from flash, sector s in bits [24s+23:24s] |
| computed_ecc | input | 96 | Codes computed on readback, same layout |
| buf_addr | output | 11 | Page buffer byte address {sector, offset} |
| buf_rd_en | output | 1 | Page buffer read request (data next cycle) |
| buf_rdata | input | 8 | Page buffer read data |
| buf_wr_en | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |
| fix_valid | output | 1 | Pulse: a correctable error was located |
| fix_sector | output | 2 | Sector of the located error |
| fix_byte | output | 9 | Byte offset within the sector |
| fix_bit | output | 3 | Bit index within the byte |
| corr_flags | output | 4 | Per-sector repaired mask for the current page |
| done | output | 1 | Pulse: page finished |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_sector | output | 2 | First uncorrectable sector (valid with status 2) |

## Verification
The assertions take two things for granted. First, the page buffer returns read data exactly one cycle after a read request. Second, the two code vectors stay stable from `start` until `done`. The bench models the buffer as a registered memory with that latency, and it changes the code vectors only while the block is idle. The stimulus builds its mismatches directly as syndromes: proper single-bit patterns with 12 bits set, counts of 1, 11, 13 and 23, and blank-sector codes. Each of these has a fault pre-planted in the buffer at the matching address, so a wrong repair shows up as a memory mismatch.

// File: rtl/pecc_pkg.sv
package pecc_pkg;
    typedef enum logic [1:0] {
        PG_CLEAN = 2'd0,
        PG_FIXED = 2'd1,
        PG_FAIL  = 2'd2
    } pg_status_e;

    typedef enum logic [1:0] {
        SEC_CLEAN = 2'd0,
        SEC_FIX   = 2'd1,
        SEC_BAD   = 2'd2
    } sec_class_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EVAL   = 3'd1,
        ST_RDWAIT = 3'd2,
        ST_MODIFY = 3'd3,
        ST_WRITE  = 3'd4
    } walk_st_e;
endpackage

// File: rtl/ecc_interleave.sv
module ecc_interleave #(
    parameter int PAIRS = 12,
    localparam int CODE_W = 2 * PAIRS
) (
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic [CODE_W-1:0] synd
);
    // code = {odd[PAIRS-1:0], even[PAIRS-1:0]}; syndrome pairs even/odd per weight
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign synd[2*k]   = code_a[k] ^ code_b[k];
        assign synd[2*k+1] = code_a[PAIRS+k] ^ code_b[PAIRS+k];
    end
endmodule

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
    import pecc_pkg::*;
#(
    parameter int PAIRS = 12,
    parameter logic [2*PAIRS-1:0] BLANK_CODE = '0,
    localparam int CODE_W = 2 * PAIRS,
    localparam int CW = $clog2(CODE_W + 1),
    localparam int BYTE_W = PAIRS - 3
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] computed,
    input  logic [CODE_W-1:0] synd,
    input  logic [CW-1:0]     cnt,
    output sec_class_e        cls,
    output logic [BYTE_W-1:0] byte_off,
    output logic [2:0]        bit_idx
);
    logic [PAIRS-1:0] odd_diff;

    // odd-weight syndrome bits carry the error position
    for (genvar k = 0; k < PAIRS; k++) begin : g_odd
        assign odd_diff[k] = synd[2*k+1];
    end

    assign bit_idx  = odd_diff[2:0];
    assign byte_off = odd_diff[PAIRS-1:3];

    always_comb begin
        if (stored == computed) begin
            cls = SEC_CLEAN;
        end else if ((&stored) && (computed == BLANK_CODE)) begin
            cls = SEC_CLEAN;
        end else if (cnt == CW'(PAIRS)) begin
            cls = SEC_FIX;
        end else begin
            cls = SEC_BAD;
        end
    end
endmodule

// File: rtl/page_ecc_corrector.sv
module page_ecc_corrector
    import pecc_pkg::*;
#(
    parameter int SECTORS      = 4,
    parameter int SECTOR_BYTES = 512,
    parameter logic [2*$clog2(SECTOR_BYTES*8)-1:0] BLANK_CODE = '0,
    localparam int PAIRS  = $clog2(SECTOR_BYTES * 8),
    localparam int ECC_W  = 2 * PAIRS,
    localparam int CW     = $clog2(ECC_W + 1),
    localparam int BYTE_W = PAIRS - 3,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1,
    localparam int ADDR_W = SEC_W + BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [SECTORS*ECC_W-1:0] stored_ecc,
    input  logic [SECTORS*ECC_W-1:0] computed_ecc,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic                     buf_rd_en,
    input  logic [7:0]               buf_rdata,
    output logic                     buf_wr_en,
    output logic [7:0]               buf_wdata,
    output logic                     fix_valid,
    output logic [SEC_W-1:0]         fix_sector,
    output logic [BYTE_W-1:0]        fix_byte,
    output logic [2:0]               fix_bit,
    output logic [SECTORS-1:0]       corr_flags,
    output logic                     done,
    output logic [1:0]               status,
    output logic [SEC_W-1:0]         err_sector
);
    localparam logic [SEC_W-1:0] LAST_SEC = SEC_W'(SECTORS - 1);

    typedef struct packed {
        walk_st_e           st;
        logic [SEC_W-1:0]   sec;
        logic [SECTORS-1:0] flags;
        logic               rd;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [7:0]         wdata;
        logic [2:0]         bidx;
        logic               fix_v;
        logic               done;
        pg_status_e         status;
        logic [SEC_W-1:0]   err_sec;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [ECC_W-1:0]  cur_stored, cur_computed, synd;
    logic [CW-1:0]     synd_cnt;
    sec_class_e        cls;
    logic [BYTE_W-1:0] byte_off;
    logic [2:0]        bit_idx;
    logic              adv;

    assign cur_stored   = stored_ecc[r_q.sec*ECC_W +: ECC_W];
    assign cur_computed = computed_ecc[r_q.sec*ECC_W +: ECC_W];

    ecc_interleave #(.PAIRS(PAIRS)) u_interleave (
        .code_a (cur_stored),
        .code_b (cur_computed),
        .synd   (synd)
    );

    ecc_popcount #(.W(ECC_W)) u_popcount (
        .vec (synd),
        .cnt (synd_cnt)
    );

    ecc_classify #(.PAIRS(PAIRS), .BLANK_CODE(BLANK_CODE)) u_classify (
        .stored   (cur_stored),
        .computed (cur_computed),
        .synd     (synd),
        .cnt      (synd_cnt),
        .cls      (cls),
        .byte_off (byte_off),
        .bit_idx  (bit_idx)
    );

    always_comb begin
        r_d       = r_q;
        r_d.rd    = 1'b0;
        r_d.wr    = 1'b0;
        r_d.fix_v = 1'b0;
        r_d.done  = 1'b0;
        adv       = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_EVAL;
                    r_d.sec   = '0;
                    r_d.flags = '0;
                end
            end
            ST_EVAL: begin
                case (cls)
                    SEC_FIX: begin
                        r_d.rd    = 1'b1;
                        r_d.fix_v = 1'b1;
                        r_d.addr  = {r_q.sec, byte_off};
                        r_d.bidx  = bit_idx;
                        r_d.st    = ST_RDWAIT;
                    end
                    SEC_BAD: begin
                        r_d.done    = 1'b1;
                        r_d.status  = PG_FAIL;
                        r_d.err_sec = r_q.sec;
                        r_d.st      = ST_IDLE;
                    end
                    default: adv = 1'b1;
                endcase
            end
            ST_RDWAIT: r_d.st = ST_MODIFY;
            ST_MODIFY: begin
                r_d.wdata = buf_rdata ^ (8'd1 << r_q.bidx);
                r_d.wr    = 1'b1;
                r_d.st    = ST_WRITE;
            end
            ST_WRITE: begin
                r_d.flags[r_q.sec] = 1'b1;
                adv                = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (adv) begin
            if (r_q.sec == LAST_SEC) begin
                r_d.done   = 1'b1;
                r_d.status = (|r_d.flags) ? PG_FIXED : PG_CLEAN;
                r_d.st     = ST_IDLE;
            end else begin
                r_d.sec = r_q.sec + SEC_W'(1);
                r_d.st  = ST_EVAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign buf_addr   = r_q.addr;
    assign buf_rd_en  = r_q.rd;
    assign buf_wr_en  = r_q.wr;
    assign buf_wdata  = r_q.wdata;
    assign fix_valid  = r_q.fix_v;
    assign fix_sector = r_q.addr[ADDR_W-1:BYTE_W];
    assign fix_byte   = r_q.addr[BYTE_W-1:0];
    assign fix_bit    = r_q.bidx;
    assign corr_flags = r_q.flags;
    assign done       = r_q.done;
    assign status     = r_q.status;
    assign err_sector = r_q.err_sec;

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: reserved status code never reported
    p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3));

    // R5: write follows its read by two cycles at the same address
    p_rmw_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en, 2) && (buf_addr == $past(buf_addr, 2))));

    // R5: written byte differs from the byte read in exactly one bit
    p_single_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($countones(buf_wdata ^ $past(buf_rdata)) == 1));

    // R5: the repaired sector is flagged after the write
    p_flag_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> corr_flags[$past(fix_sector)]);

    // R5: never read and write the buffer together
    p_no_rw_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));
endmodule

// File: tb/tb_page_ecc_corrector.sv
`timescale 1ns/1ps
module tb_page_ecc_corrector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [95:0] stored_ecc = '0;
    logic [95:0] computed_ecc = '0;
    logic [10:0] buf_addr;
    logic        buf_rd_en;
    logic [7:0]  buf_rdata;
    logic        buf_wr_en;
    logic [7:0]  buf_wdata;
    logic        fix_valid;
    logic [1:0]  fix_sector;
    logic [8:0]  fix_byte;
    logic [2:0]  fix_bit;
    logic [3:0]  corr_flags;
    logic        done;
    logic [1:0]  status;
    logic [1:0]  err_sector;

    always #2.5 clk = ~clk;

    page_ecc_corrector dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_ecc(stored_ecc), .computed_ecc(computed_ecc),
        .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata),
        .fix_valid(fix_valid), .fix_sector(fix_sector), .fix_byte(fix_byte),
        .fix_bit(fix_bit), .corr_flags(corr_flags), .done(done),
        .status(status), .err_sector(err_sector)
    );

    // page buffer model: one-cycle read latency
    logic [7:0] mem [0:2047];
    logic [7:0] exp_mem [0:2047];
    int rd_count = 0;
    int done_count = 0;
    always @(posedge clk) begin
        if (buf_rd_en) begin
            buf_rdata <= mem[buf_addr];
            rd_count  <= rd_count + 1;
        end
        if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0] st;
        logic [3:0] flags;
        logic [1:0] err;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    // monitor: compare each completion with the queued expectation
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_count++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(status == e.st, {e.req, " status"}, status, e.st);
                chk(corr_flags == e.flags, {e.req, " corr_flags"}, corr_flags, e.flags);
                if (e.st == 2'd2)
                    chk(err_sector == e.err, {e.req, " err_sector"}, err_sector, e.err);
            end
        end
    end

    logic [23:0] sc [4];
    logic [23:0] cc [4];

    function automatic logic [23:0] fix_diff(input logic [8:0] b, input logic [2:0] i);
        logic [11:0] a;
        a = {b, i};
        return {a, ~a};
    endfunction

    task automatic reset_codes();
        for (int s = 0; s < 4; s++) begin
            sc[s] = 24'h3C5A96 ^ (24'h111111 * s);
            cc[s] = sc[s];
        end
    endtask

    // correctable fault: buffer gets a flipped bit, expected keeps the original
    task automatic plant_fix(input int s, input logic [8:0] b, input logic [2:0] i, input bit repaired);
        cc[s] = sc[s] ^ fix_diff(b, i);
        mem[s*512 + b] = mem[s*512 + b] ^ (8'd1 << i);
        if (!repaired) exp_mem[s*512 + b] = mem[s*512 + b];
    endtask

    task automatic run_page(input logic [1:0] st, input logic [3:0] fl, input logic [1:0] er,
                            input string req);
        exp_t e;
        int n;
        e.st = st; e.flags = fl; e.err = er; e.req = req;
        sb_q.push_back(e);
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            stored_ecc[s*24 +: 24]   = sc[s];
            computed_ecc[s*24 +: 24] = cc[s];
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (sb_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(sb_q.size() == 0, {req, " done seen"}, sb_q.size(), 0);
        sb_q.delete();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_mem(input string req);
        int bad;
        bad = 0;
        for (int a = 0; a < 2048; a++) if (mem[a] !== exp_mem[a]) bad++;
        chk(bad == 0, {req, " buffer contents"}, bad, 0);
    endtask

    task automatic fill_mem();
        for (int a = 0; a < 2048; a++) begin
            mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
            exp_mem[a] = mem[a];
        end
    endtask

    initial begin
        int r0;
        fill_mem();
        reset_codes();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0 && buf_rd_en == 0 && buf_wr_en == 0 && fix_valid == 0,
            "R1 reset outputs", {done, buf_rd_en, buf_wr_en, fix_valid}, 0);
        chk(corr_flags == 0, "R1 reset flags", corr_flags, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: all sectors match, no access
        r0 = rd_count;
        run_page(2'd0, 4'b0000, 2'd0, "R2 clean page");
        chk(rd_count == r0, "R2 no buffer access", rd_count - r0, 0);
        check_mem("R2");

        // R4/R5/R3: one correctable error in sector 1, watch the locator outputs
        reset_codes();
        plant_fix(1, 9'h1A5, 3'd6, 1);
        fork
            run_page(2'd1, 4'b0010, 2'd0, "R5 single fix");
            begin
                int n;
                n = 0;
                while (!fix_valid && n < 100) begin @(negedge clk); n++; end
                chk(fix_valid && fix_sector == 2'd1, "R4 fix_sector", fix_sector, 1);
                chk(fix_byte == 9'h1A5, "R4 fix_byte", fix_byte, 9'h1A5);
                chk(fix_bit == 3'd6, "R3 fix_bit from odd syndrome bits", fix_bit, 6);
            end
        join
        check_mem("R5 single fix");

        // R4 boundaries: byte 0 bit 0, byte 511 bit 7, in every sector
        reset_codes();
        plant_fix(0, 9'd0, 3'd0, 1);
        plant_fix(1, 9'd511, 3'd7, 1);
        plant_fix(2, 9'd256, 3'd3, 1);
        plant_fix(3, 9'd1, 3'd5, 1);
        run_page(2'd1, 4'b1111, 2'd0, "R4 four sector fixes");
        check_mem("R4 four sector fixes");

        // R3: 12 bits set but all in even positions -> locator byte 0 bit 0
        reset_codes();
        cc[2] = sc[2] ^ 24'h000FFF;
        mem[2*512] = mem[2*512] ^ 8'h01;
        run_page(2'd1, 4'b0100, 2'd0, "R3 even-only syndrome");
        check_mem("R3 even-only syndrome");

        // R6/R8: count 1 in sector 2, sector 0 fixed first, sector 3 untouched
        reset_codes();
        plant_fix(0, 9'h0F0, 3'd2, 1);
        cc[2] = sc[2] ^ 24'h000400;
        plant_fix(3, 9'h033, 3'd1, 0);
        r0 = rd_count;
        run_page(2'd2, 4'b0001, 2'd2, "R8 stop at sector 2");
        chk(rd_count - r0 == 1, "R8 later sectors not read", rd_count - r0, 1);
        check_mem("R8 stop at sector 2");

        // R6: count 11 in sector 0
        reset_codes();
        cc[0] = sc[0] ^ 24'h0007FF;
        run_page(2'd2, 4'b0000, 2'd0, "R6 count 11");

        // R6: count 13 in sector 3
        reset_codes();
        cc[3] = sc[3] ^ 24'h001FFF;
        run_page(2'd2, 4'b0000, 2'd3, "R6 count 13");

        // R7: erased sector (stored all ones, computed blank) is clean
        reset_codes();
        sc[1] = 24'hFFFFFF; cc[1] = 24'h000000;
        r0 = rd_count;
        run_page(2'd0, 4'b0000, 2'd0, "R7 erased sector");
        chk(rd_count == r0, "R7 no buffer access", rd_count - r0, 0);

        // R7: erased stored code but computed not blank -> uncorrectable (count 23)
        reset_codes();
        sc[1] = 24'hFFFFFF; cc[1] = 24'h000001;
        run_page(2'd2, 4'b0000, 2'd1, "R7 not blank");

        // R10: start while busy is ignored
        reset_codes();
        plant_fix(2, 9'h077, 3'd4, 1);
        r0 = done_count;
        fork
            run_page(2'd1, 4'b0100, 2'd0, "R10 busy start");
            begin
                repeat (3) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(done_count - r0 == 1, "R10 single completion", done_count - r0, 1);
        check_mem("R10 busy start");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule